// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers every interrupt source of a small 8-bit controller and tells the CPU which one to serve next. It handles seven sources: the boot (reset) request, a non-maskable request raised by timer B, and five maskable requests. The maskable ones are coprocessor-done, ADC, timer, a port-A pin change and the external pin. A fixed priority chain picks one winner. The block presents that winner's 16-bit vector address, which lies in a table at the top of the address space.

Each source has a kind of request. The boot request and the non-maskable request are latched flags. The port-A pin-change event is also a latched flag. The coprocessor, ADC, timer and external requests are levels that the peripherals hold until they are serviced. One global mask input blocks all the maskable sources together. The non-maskable line ignores that mask.

The block keeps its own small set of enable bits, which are written through a byte-wide strobe interface. It holds a port-A per-pin enable byte that is active low. It holds a timer control byte, whose bits enable the timer request and the non-maskable request. It also holds a system control byte, whose bit enables the external pin function. When the CPU pulses acknowledge, only the flag of the source being presented is cleared.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset is released, `boot_req` is 1 and `vec_addr` is 16'hFFFC. This lasts until an acknowledge clears it, and the boot request never comes back without a new reset. Reset clears every enable: the port-A enable byte resets to 8'hFF, and the timer and external enables reset to 0.
- R2: The priority from highest to lowest is boot, non-maskable, coprocessor-done, ADC, timer, port A, external.
- R3: The vector addresses are as follows. Coprocessor-done uses 16'hFFF0, ADC 16'hFFF2, timer 16'hFFF6, port A 16'hFFF8, non-maskable 16'hFFFA, boot 16'hFFFC and external 16'hFFFE. The address 16'hFFF4 is never presented. When there is no winner, `vec_valid` is 0 and `vec_addr` is 0.
- R4: A rising edge of `tmrb_evt` that is sampled while the non-maskable enable is set latches `nmi_req` one cycle later. A level held high on `tmrb_evt` gives only one latch. The flag stays set regardless of `global_mask` until it is acknowledged.
- R5: An edge of `tmrb_evt` that arrives while the non-maskable enable is clear is dropped. Setting the enable afterwards does not latch that earlier edge.
- R6: The timer level request takes part only while timer-control bit 4 is 1.
- R7: The external pin request takes part only while system-control bit 1 is 1.
- R8: Port-A pin `i` is enabled when bit `i` of the enable byte is 0. A change of an enabled pin, in either direction, sets the port-A flag 3 clock edges after the pin changes. The pin first passes through 2 synchronizer stages and then a compare against the previous sample. Changes on disabled pins are ignored.
- R9: While `global_mask` is 1, `irq_req` is 0 and no maskable source wins. A latched port-A flag is kept and is presented again once the mask drops.
- R10: An acknowledge clears only the latched flag of the source presented in that cycle. If that source is boot, non-maskable or port A, its flag is cleared and the other pending flags remain set. If the winner is a level source, the acknowledge does not change any state.
- R11: `wr_sel` selects the target of a write on `wr_en`: 0 is system control, 1 is timer control (bit 4 enables the timer request, bit 5 enables the non-maskable request), and 2 is the port-A enable byte. A write with `wr_sel` = 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the enable registers |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | DW (8) | Write data byte |
| tmrb_evt | input | 1 | Timer B event; its rising edge raises the non-maskable request |
| cop_done | input | 1 | Coprocessor-done level request |
| adc_req | input | 1 | ADC level request |
| tmra_req | input | 1 | Timer level request |
| ext_pin | input | 1 | External interrupt pin level |
| pa_pins | input | PA_W (8) | Raw port-A pins, asynchronous |
| global_mask | input | 1 | 1 blocks all maskable sources |
| ack | input | 1 | CPU acknowledge of the presented vector |
| boot_req | output | 1 | Boot (reset) vector pending |
| nmi_req | output | 1 | Non-maskable request to the CPU |
| irq_req | output | 1 | Any unmasked, enabled maskable request |
| vec_valid | output | 1 | A winner exists |
| vec_addr | output | 16 | Vector address of the winner, 0 if none |

## Verification
The hardest case to reach is several latched flags pending at once while level requests are also active. That case is needed to show that one acknowledge removes only the presented flag. The stimulus first sets up a port-A change. Because of the synchronizer and compare latency, this takes three edges before the flag appears. Only then does it raise a timer B edge, so both flags are pending together. Separately, it raises the timer B edge while the non-maskable enable is clear and sets the enable later, to show that the stale edge is never latched. A long random phase follows. In that phase a behavioural model predicts every output on every cycle while acknowledges, mask changes, writes and pin toggles overlap.

// File: rtl/irq_pkg.sv
package irq_pkg;

   // Priority order: lower value wins.
   typedef enum logic [2:0] {
      SRC_RST = 3'd0,
      SRC_NMI = 3'd1,
      SRC_COP = 3'd2,
      SRC_ADC = 3'd3,
      SRC_TMR = 3'd4,
      SRC_PA  = 3'd5,
      SRC_EXT = 3'd6
   } irq_src_e;

   localparam int NUM_SRC = 7;

   localparam logic [1:0] SEL_SYS  = 2'd0;
   localparam logic [1:0] SEL_TMR  = 2'd1;
   localparam logic [1:0] SEL_PAEN = 2'd2;

   // Word slot inside the vector table (address = base + 2*slot).
   function automatic logic [2:0] vec_slot(input irq_src_e src);
      case (src)
         SRC_COP: return 3'd0;
         SRC_ADC: return 3'd1;
         SRC_TMR: return 3'd3;
         SRC_PA:  return 3'd4;
         SRC_NMI: return 3'd5;
         SRC_RST: return 3'd6;
         SRC_EXT: return 3'd7;
         default: return 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pins,
   output logic [WIDTH-1:0] changed
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_pin_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("irq_pin_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain [STAGES];
   logic [WIDTH-1:0] prev_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= pins;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= chain[LAST];
   end

   assign changed = chain[LAST] ^ prev_q;

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
   import irq_pkg::*;
#(
   parameter int DW          = 8,
   parameter int PA_W        = 8,
   parameter int EXT_EN_BIT  = 1,
   parameter int TMR_EN_BIT  = 4,
   parameter int NMI_EN_BIT  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [DW-1:0]   wr_data,
   output logic            ext_en,
   output logic            tmr_en,
   output logic            nmi_en,
   output logic [PA_W-1:0] pa_en_n
);

   if (PA_W != DW) begin : g_bad_pa_w
      $error("irq_cfg_regs: PA_W must equal DW");
   end
   if (EXT_EN_BIT >= DW || TMR_EN_BIT >= DW || NMI_EN_BIT >= DW) begin : g_bad_bit
      $error("irq_cfg_regs: enable bit position out of range");
   end
   if (TMR_EN_BIT == NMI_EN_BIT) begin : g_bad_overlap
      $error("irq_cfg_regs: timer and NMI enables must differ");
   end

   logic wr_sys, wr_tmr, wr_pa;

   assign wr_sys = wr_en && (wr_sel == SEL_SYS);
   assign wr_tmr = wr_en && (wr_sel == SEL_TMR);
   assign wr_pa  = wr_en && (wr_sel == SEL_PAEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ext_en <= 1'b0;
      end else if (wr_sys) begin
         ext_en <= wr_data[EXT_EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_en <= 1'b0;
         nmi_en <= 1'b0;
      end else if (wr_tmr) begin
         tmr_en <= wr_data[TMR_EN_BIT];
         nmi_en <= wr_data[NMI_EN_BIT];
      end
   end

   // Active low: 1 = pin disabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_en_n <= '1;
      end else if (wr_pa) begin
         pa_en_n <= wr_data[PA_W-1:0];
      end
   end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int N  = 7,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   if (N < 2) begin : g_bad_n
      $error("irq_prio_sel: N must be at least 2");
   end

   // Thermometer of "a higher-priority request exists".
   logic [N-1:0] above;

   assign above[0] = 1'b0;
   for (genvar i = 1; i < N; i++) begin : g_above
      assign above[i] = above[i-1] | req[i-1];
   end

   for (genvar i = 0; i < N; i++) begin : g_grant
      assign grant[i] = req[i] & ~above[i];
   end

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_pkg::*;
#(
   parameter int          DW          = 8,
   parameter int          PA_W        = 8,
   parameter int          SYNC_STAGES = 2,
   parameter logic [15:0] VEC_BASE    = 16'hFFF0,
   parameter int          EXT_EN_BIT  = 1,
   parameter int          TMR_EN_BIT  = 4,
   parameter int          NMI_EN_BIT  = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_sel,
   input  logic [DW-1:0]   wr_data,
   input  logic            tmrb_evt,
   input  logic            cop_done,
   input  logic            adc_req,
   input  logic            tmra_req,
   input  logic            ext_pin,
   input  logic [PA_W-1:0] pa_pins,
   input  logic            global_mask,
   input  logic            ack,
   output logic            boot_req,
   output logic            nmi_req,
   output logic            irq_req,
   output logic            vec_valid,
   output logic [15:0]     vec_addr
);

   localparam int IW = $clog2(NUM_SRC);

   if (VEC_BASE[3:0] != 4'h0) begin : g_bad_base
      $error("irq_vector_ctrl: VEC_BASE must be 16-byte aligned");
   end

   logic            ext_en, tmr_en, nmi_en;
   logic [PA_W-1:0] pa_en_n;
   logic [PA_W-1:0] pa_chg;
   logic [NUM_SRC-1:0] req, grant;
   logic [IW-1:0]   win_idx;
   logic            win_any;
   logic            boot_q, nmi_q, pa_q, tmrb_prev;
   logic            nmi_set, pa_set;
   logic [2:0]      slot;

   irq_cfg_regs #(
      .DW(DW), .PA_W(PA_W), .EXT_EN_BIT(EXT_EN_BIT),
      .TMR_EN_BIT(TMR_EN_BIT), .NMI_EN_BIT(NMI_EN_BIT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ext_en(ext_en), .tmr_en(tmr_en),
      .nmi_en(nmi_en), .pa_en_n(pa_en_n)
   );

   irq_pin_sync #(.WIDTH(PA_W), .STAGES(SYNC_STAGES)) u_pa_sync (
      .clk(clk), .rst_n(rst_n), .pins(pa_pins), .changed(pa_chg)
   );

   assign nmi_set = tmrb_evt & ~tmrb_prev & nmi_en;
   assign pa_set  = |(pa_chg & ~pa_en_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boot_q    <= 1'b1;
         nmi_q     <= 1'b0;
         pa_q      <= 1'b0;
         tmrb_prev <= 1'b0;
      end else begin
         tmrb_prev <= tmrb_evt;
         if (ack && grant[int'(SRC_RST)]) boot_q <= 1'b0;
         if (nmi_set)                            nmi_q <= 1'b1;
         else if (ack && grant[int'(SRC_NMI)])   nmi_q <= 1'b0;
         if (pa_set)                             pa_q <= 1'b1;
         else if (ack && grant[int'(SRC_PA)])    pa_q <= 1'b0;
      end
   end

   always_comb begin
      req                = '0;
      req[int'(SRC_RST)] = boot_q;
      req[int'(SRC_NMI)] = nmi_q;
      req[int'(SRC_COP)] = cop_done & ~global_mask;
      req[int'(SRC_ADC)] = adc_req & ~global_mask;
      req[int'(SRC_TMR)] = tmra_req & tmr_en & ~global_mask;
      req[int'(SRC_PA)]  = pa_q & ~global_mask;
      req[int'(SRC_EXT)] = ext_pin & ext_en & ~global_mask;
   end

   irq_prio_sel #(.N(NUM_SRC), .IW(IW)) u_prio (
      .req(req), .grant(grant), .idx(win_idx), .any(win_any)
   );

   assign slot      = vec_slot(irq_src_e'(win_idx));
   assign boot_req  = boot_q;
   assign nmi_req   = nmi_q;
   assign irq_req   = |req[NUM_SRC-1:int'(SRC_COP)];
   assign vec_valid = win_any;
   assign vec_addr  = win_any ? (VEC_BASE | 16'({slot, 1'b0})) : 16'h0000;

endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter logic [15:0] VEC_BASE = 16'hFFF0
) (
   input logic        clk,
   input logic        rst_n,
   input logic        tmrb_evt,
   input logic        global_mask,
   input logic        ack,
   input logic        boot_req,
   input logic        nmi_req,
   input logic        irq_req,
   input logic        vec_valid,
   input logic [15:0] vec_addr
);

   AST_BOOT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      boot_req |-> (vec_valid && vec_addr == (VEC_BASE | 16'h000C))); // R1

   AST_BOOT_NO_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_req |=> !boot_req); // R1

   AST_NMI_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && !boot_req) |-> (vec_addr == (VEC_BASE | 16'h000A))); // R2

   AST_NO_UNUSED_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_addr != (VEC_BASE | 16'h0004))); // R3

   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec_addr == 16'h0000 && !boot_req && !nmi_req && !irq_req)); // R3

   AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (nmi_req && !(ack && !boot_req)) |=> nmi_req); // R4

   AST_NMI_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_req) |-> $past(tmrb_evt)); // R5

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      global_mask |-> !irq_req); // R9

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.VEC_BASE(VEC_BASE)) u_chk (
   .clk(clk), .rst_n(rst_n), .tmrb_evt(tmrb_evt), .global_mask(global_mask),
   .ack(ack), .boot_req(boot_req), .nmi_req(nmi_req), .irq_req(irq_req),
   .vec_valid(vec_valid), .vec_addr(vec_addr)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [7:0]  wr_data = 8'h00;
   logic        tmrb_evt = 1'b0, cop_done = 1'b0, adc_req = 1'b0;
   logic        tmra_req = 1'b0, ext_pin = 1'b0, global_mask = 1'b0, ack = 1'b0;
   logic [7:0]  pa_pins = 8'h00;
   logic        boot_req, nmi_req, irq_req, vec_valid;
   logic [15:0] vec_addr;

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 0;
   string phase  = "R1";

   irq_vector_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .tmrb_evt(tmrb_evt), .cop_done(cop_done), .adc_req(adc_req),
      .tmra_req(tmra_req), .ext_pin(ext_pin), .pa_pins(pa_pins),
      .global_mask(global_mask), .ack(ack), .boot_req(boot_req),
      .nmi_req(nmi_req), .irq_req(irq_req), .vec_valid(vec_valid),
      .vec_addr(vec_addr)
   );

   // ---------------- reference model ----------------
   bit       m_boot, m_nmi, m_pa, m_prev_tmrb;
   bit       m_ext_en, m_tmr_en, m_nmi_en;
   bit [7:0] m_en_n;
   bit [7:0] m_hist[$];

   function automatic int m_winner();
      if (m_boot) return 1;
      if (m_nmi) return 2;
      if (global_mask) return 0;
      if (cop_done) return 3;
      if (adc_req) return 4;
      if (tmra_req && m_tmr_en) return 5;
      if (m_pa) return 6;
      if (ext_pin && m_ext_en) return 7;
      return 0;
   endfunction

   function automatic int addr_of(int w);
      case (w)
         1: return 16'hFFFC;
         2: return 16'hFFFA;
         3: return 16'hFFF0;
         4: return 16'hFFF2;
         5: return 16'hFFF6;
         6: return 16'hFFF8;
         7: return 16'hFFFE;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int  w;
      bit  chg;
      if (!rst_n) begin
         m_boot = 1; m_nmi = 0; m_pa = 0; m_prev_tmrb = 0;
         m_ext_en = 0; m_tmr_en = 0; m_nmi_en = 0; m_en_n = 8'hFF;
         m_hist = {8'h00, 8'h00, 8'h00};
      end else begin
         w   = m_winner();
         chg = (((m_hist[1] ^ m_hist[2]) & ~m_en_n) != 8'h00);
         if (ack && w == 1) m_boot = 0;
         if (ack && w == 2) m_nmi = 0;
         if (tmrb_evt && !m_prev_tmrb && m_nmi_en) m_nmi = 1;
         if (ack && w == 6) m_pa = 0;
         if (chg) m_pa = 1;
         m_prev_tmrb = tmrb_evt;
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_ext_en = wr_data[1];
               2'd1: begin m_tmr_en = wr_data[4]; m_nmi_en = wr_data[5]; end
               2'd2: m_en_n = wr_data;
               default: ;
            endcase
         end
         m_hist.push_front(pa_pins);
         void'(m_hist.pop_back());
      end
   end

   task automatic check_eq(string tag, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         int w;
         bit m_irq;
         w = m_winner();
         m_irq = !global_mask && (cop_done || adc_req || (tmra_req && m_tmr_en) ||
                                  m_pa || (ext_pin && m_ext_en));
         check_eq(phase, {boot_req, nmi_req, irq_req, vec_valid},
                  {m_boot, m_nmi, m_irq, (w != 0)}, "model flags");
         check_eq(phase, vec_addr, addr_of(w), "model vec_addr");
      end
   end

   // ---------------- directed helpers ----------------
   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(string tag, bit eb, bit en, bit ei, bit ev, int ea);
      @(negedge clk);
      check_eq(tag, {boot_req, nmi_req, irq_req, vec_valid}, {eb, en, ei, ev}, "flags");
      check_eq(tag, vec_addr, ea, "vec_addr");
      @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [1:0] s, logic [7:0] d);
      wr_en = 1; wr_sel = s; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0;
   endtask

   task automatic do_ack();
      ack = 1;
      @(posedge clk); #1;
      ack = 0;
   endtask

   task automatic pulse_tmrb();
      tmrb_evt = 1;
      @(posedge clk); #1;
      tmrb_evt = 0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1;
      // R1: boot vector after reset
      phase = "R1";
      chk("R1", 1, 0, 0, 1, 16'hFFFC);
      chk("R1", 1, 0, 0, 1, 16'hFFFC);
      do_ack();
      chk("R1", 0, 0, 0, 0, 0);
      // R8: all pins disabled after reset
      phase = "R8";
      pa_pins = 8'h01;
      tick(4);
      chk("R8", 0, 0, 0, 0, 0);

      // R3 / R2: level sources
      phase = "R3";
      cop_done = 1;
      chk("R3", 0, 0, 1, 1, 16'hFFF0);
      adc_req = 1;
      chk("R2", 0, 0, 1, 1, 16'hFFF0);
      cop_done = 0;
      chk("R3", 0, 0, 1, 1, 16'hFFF2);
      adc_req = 0;

      // R6: timer enable
      phase = "R6";
      tmra_req = 1;
      chk("R6", 0, 0, 0, 0, 0);
      wr(2'd1, 8'h10);
      chk("R6", 0, 0, 1, 1, 16'hFFF6);

      // R5: edge with NMI disabled is dropped
      phase = "R5";
      pulse_tmrb();
      chk("R5", 0, 0, 1, 1, 16'hFFF6);
      wr(2'd1, 8'h30);
      chk("R5", 0, 0, 1, 1, 16'hFFF6);

      // R4: latched NMI ignores mask
      phase = "R4";
      pulse_tmrb();
      chk("R4", 0, 1, 1, 1, 16'hFFFA);
      global_mask = 1;
      chk("R4", 0, 1, 0, 1, 16'hFFFA);
      tick(5);
      chk("R4", 0, 1, 0, 1, 16'hFFFA);
      global_mask = 0;
      do_ack();
      chk("R10", 0, 0, 1, 1, 16'hFFF6);
      tmra_req = 0;
      tmrb_evt = 1;
      tick(1);
      chk("R4", 0, 1, 0, 1, 16'hFFFA);
      do_ack();
      chk("R4", 0, 0, 0, 0, 0);
      tmrb_evt = 0;

      // R7: external pin gating
      phase = "R7";
      ext_pin = 1;
      chk("R7", 0, 0, 0, 0, 0);
      wr(2'd0, 8'h02);
      chk("R7", 0, 0, 1, 1, 16'hFFFE);
      wr(2'd0, 8'h00);
      chk("R7", 0, 0, 0, 0, 0);
      ext_pin = 0;

      // R8: active-low pin enable, 3-edge latency
      phase = "R8";
      wr(2'd2, 8'hFE);
      pa_pins = 8'h00;
      tick(2);
      chk("R8", 0, 0, 0, 0, 0);
      chk("R8", 0, 0, 1, 1, 16'hFFF8);
      do_ack();
      chk("R10", 0, 0, 0, 0, 0);
      pa_pins = 8'h02;
      tick(4);
      chk("R8", 0, 0, 0, 0, 0);
      pa_pins = 8'h03;
      tick(3);
      chk("R8", 0, 0, 1, 1, 16'hFFF8);

      // R9: mask hides but keeps port-A flag
      phase = "R9";
      global_mask = 1;
      chk("R9", 0, 0, 0, 0, 0);
      tick(3);
      chk("R9", 0, 0, 0, 0, 0);
      global_mask = 0;
      chk("R9", 0, 0, 1, 1, 16'hFFF8);

      // R10: ack clears only the presented flag
      phase = "R10";
      pulse_tmrb();
      chk("R10", 0, 1, 1, 1, 16'hFFFA);
      do_ack();
      chk("R10", 0, 0, 1, 1, 16'hFFF8);
      do_ack();
      chk("R10", 0, 0, 0, 0, 0);
      adc_req = 1;
      do_ack();
      chk("R10", 0, 0, 1, 1, 16'hFFF2);
      adc_req = 0;

      // R11: select 3 writes nothing
      phase = "R11";
      wr(2'd3, 8'h00);
      tmra_req = 1;
      chk("R11", 0, 0, 1, 1, 16'hFFF6);
      wr(2'd3, 8'hFF);
      tmra_req = 0;
      ext_pin = 1;
      chk("R11", 0, 0, 0, 0, 0);
      ext_pin = 0;

      // R2: full priority walk
      phase = "R2";
      wr(2'd0, 8'h02);
      pa_pins = 8'h02;
      tick(3);
      ext_pin = 1; tmra_req = 1; adc_req = 1; cop_done = 1;
      pulse_tmrb();
      chk("R2", 0, 1, 1, 1, 16'hFFFA);
      do_ack();
      chk("R2", 0, 0, 1, 1, 16'hFFF0);
      cop_done = 0;
      chk("R2", 0, 0, 1, 1, 16'hFFF2);
      adc_req = 0;
      chk("R2", 0, 0, 1, 1, 16'hFFF6);
      tmra_req = 0;
      chk("R2", 0, 0, 1, 1, 16'hFFF8);
      do_ack();
      chk("R2", 0, 0, 1, 1, 16'hFFFE);
      ext_pin = 0;
      chk("R2", 0, 0, 0, 0, 0);

      // Random phase checked by the model every cycle (R2, R10)
      phase = "R10";
      for (int i = 0; i < 3000; i++) begin
         cop_done    = ($urandom_range(0, 7) == 0);
         adc_req     = ($urandom_range(0, 5) == 0);
         tmra_req    = ($urandom_range(0, 3) == 0);
         ext_pin     = ($urandom_range(0, 2) == 0);
         global_mask = ($urandom_range(0, 5) == 0);
         ack         = ($urandom_range(0, 2) == 0);
         tmrb_evt    = ($urandom_range(0, 6) == 0);
         if ($urandom_range(0, 4) == 0) pa_pins = pa_pins ^ 8'(1 << $urandom_range(0, 7));
         wr_en   = ($urandom_range(0, 15) == 0);
         wr_sel  = 2'($urandom_range(0, 3));
         wr_data = 8'($urandom_range(0, 255));
         tick(1);
      end
      ack = 0; wr_en = 0;
      tick(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule